// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Flag Qualifier

This block sits between an analog current-sense comparator and the protection response of a switching converter. It turns the raw comparator output into two fault flags. The cycle flag reports a qualified overcurrent in the present switching period and clears when the next period begins. The latched flag records that a qualified overcurrent has happened and stays set until an explicit clear.

Three filters stand between the comparator and the flags. A leading-edge blanking window hides the turn-on current spike. The window opens on the rising edge of one of four PWM reference outputs, picked by a select input. A debounce requires the comparator to stay high for a minimum time before a trip is recorded. A timeout requires a run of consecutive tripped switching cycles before either flag may assert. The comparator enters through a two-flop synchronizer, and all timing counts ticks of a 40 ns clock.

The window logic is a four-state machine. `ST_WATCH` is armed with the comparator low. `ST_DEBOUNCE` counts consecutive high samples. `ST_BLANK` counts down the blanking window. `ST_HIT` means a trip was recorded in this switching cycle, and it ignores the comparator until the cycle ends. The transitions are:
- WATCH→DEBOUNCE on the first high sample when the debounce length is non-zero.
- WATCH→HIT on the first high sample when the debounce length is zero.
- DEBOUNCE→WATCH on a low sample.
- DEBOUNCE→HIT once enough consecutive high samples have been seen.
- BLANK→WATCH when the window count runs out.
- HIT→WATCH on the cycle-start pulse.
- Any state except HIT goes to BLANK (or to WATCH when the blanking length is zero) on a reference rising edge. HIT does this only when the cycle-start pulse arrives in the same clock.

Top module: `ocp_cycle_flag`

## Requirements
- R1: After reset, and during any reset, asynchronous or not, both `cyc_flag` and `lat_flag` read 0.
- R2: Only a rising edge of `pwm_ref[ref_sel]` (bit index given by `ref_sel`) opens a blanking window. Edges on the other reference bits have no effect.
- R3: `blank_code` 0..7 selects a window of 0, 1, 2, 3, 5, 10, 15 or 20 clock cycles (0 to 800 ns). If the reference rise is seen at clock edge E, the comparator is ignored at edges E through E+N.
- R4: A level applied to `cmp_raw` before clock edge k is first seen by the trip logic at edge k+2. With blanking and debounce at 0, `cyc_flag` therefore reads 1 just after edge k+2 and not before.
- R5: `deb_code` d (0..3, that is 0/40/80/120 ns) requires d+1 consecutive unblanked synchronized high samples. The trip is recorded on the last of them. A low sample restarts the count.
- R6: `cyc_flag` rises on the edge of a qualified trip and stays 1 until the first edge with `cycle_start` high.
- R7: `tmo_code` 0..3 requires 1, 2, 4 or 8 consecutive tripped switching cycles; the flags assert only on a trip in the last cycle of such a run. A cycle that ends without a trip resets the run to zero. The run count saturates at 7, so further tripped cycles keep qualifying.
- R8: `lat_flag` sets on every qualified trip. It is not cleared by `cycle_start`, and it clears on a clock edge with `latch_clr` high.
- R9: When a qualified trip and `latch_clr` fall on the same clock edge, `lat_flag` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz clock (40 ns tick) |
| rst_n | input | 1 | asynchronous active-low reset |
| cmp_raw | input | 1 | raw overcurrent comparator output, asynchronous |
| pwm_ref | input | NREF (4) | candidate PWM reference outputs |
| ref_sel | input | $clog2(NREF) (2) | index of the reference whose rising edge opens blanking |
| cycle_start | input | 1 | one-clock pulse at the start of each switching cycle |
| blank_code | input | 3 | blanking window code |
| deb_code | input | DEB_W (2) | debounce length code |
| tmo_code | input | TMO_W (2) | consecutive-cycle timeout code |
| latch_clr | input | 1 | clears the latched flag |
| cyc_flag | output | 1 | per-switching-cycle overcurrent flag |
| lat_flag | output | 1 | latched overcurrent flag |

## Verification
The bench builds the block at its default parameters: four references, two synchronizer stages and a 40 ns tick. These defaults make the longest blanking window 20 cycles, which fits inside the bench's 31-clock switching period. Comparator pulses can therefore be placed on either side of every window boundary. With a two-bit timeout code, the eight-cycle run and the saturation of the run counter at seven are both reachable within nine switching cycles, so the bench exercises both.

// File: rtl/ocp_flag_pkg.sv
package ocp_flag_pkg;

    typedef enum logic [1:0] {
        ST_WATCH    = 2'd0,
        ST_BLANK    = 2'd1,
        ST_DEBOUNCE = 2'd2,
        ST_HIT      = 2'd3
    } win_state_t;

    localparam int BLANK_CODE_W = 3;
    localparam int BLANK_MAX_NS = 800;

    // Blanking length in ns: fine steps of 40 ns up to code 3, then 200 ns steps.
    function automatic int blank_ns(input logic [BLANK_CODE_W-1:0] code);
        if (code < 3'd4)
            return int'(code) * 40;
        else
            return (int'(code) - 3) * 200;
    endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ocp_ref_edge.sv
module ocp_ref_edge #(
    parameter int NREF = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREF-1:0]         pwm_ref,
    input  logic [$clog2(NREF)-1:0] ref_sel,
    output logic                    ref_rise
);
    logic sel_now;
    logic sel_prev;

    assign sel_now = pwm_ref[ref_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel_now;
    end

    assign ref_rise = sel_now & ~sel_prev;
endmodule

// File: rtl/ocp_window_fsm.sv
module ocp_window_fsm
    import ocp_flag_pkg::*;
#(
    parameter int BW    = 5,
    parameter int DEB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             cycle_start,
    input  logic             cmp_s,
    input  logic [BW-1:0]    blank_len,
    input  logic [DEB_W-1:0] deb_len,
    output win_state_t       st,
    output logic             trip,
    output logic             in_hit
);
    win_state_t       st_n;
    logic [BW-1:0]    bcnt, bcnt_n;
    logic [DEB_W-1:0] run, run_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_WATCH;
            bcnt <= '0;
            run  <= '0;
        end else begin
            st   <= st_n;
            bcnt <= bcnt_n;
            run  <= run_n;
        end
    end

    // Next state
    always_comb begin
        st_n   = st;
        bcnt_n = bcnt;
        run_n  = run;
        unique case (st)
            ST_WATCH: begin
                if (cmp_s) begin
                    if (trip) begin
                        st_n  = ST_HIT;
                        run_n = '0;
                    end else begin
                        st_n  = ST_DEBOUNCE;
                        run_n = DEB_W'(1);
                    end
                end
            end
            ST_DEBOUNCE: begin
                if (!cmp_s) begin
                    st_n  = ST_WATCH;
                    run_n = '0;
                end else if (trip) begin
                    st_n  = ST_HIT;
                    run_n = '0;
                end else begin
                    run_n = run + DEB_W'(1);
                end
            end
            ST_BLANK: begin
                bcnt_n = (bcnt == '0) ? '0 : bcnt - BW'(1);
                if (bcnt <= BW'(1)) st_n = ST_WATCH;
            end
            ST_HIT: begin
                if (cycle_start) st_n = ST_WATCH;
            end
        endcase
        if (ref_rise && (st != ST_HIT || cycle_start)) begin
            run_n = '0;
            if (blank_len != '0) begin
                st_n   = ST_BLANK;
                bcnt_n = blank_len;
            end else begin
                st_n   = ST_WATCH;
                bcnt_n = '0;
            end
        end
    end

    // Outputs
    always_comb begin
        trip   = !ref_rise && cmp_s &&
                 ((st == ST_WATCH    && deb_len == '0) ||
                  (st == ST_DEBOUNCE && run >= deb_len));
        in_hit = (st == ST_HIT);
    end
endmodule

// File: rtl/ocp_trip_track.sv
module ocp_trip_track #(
    parameter int TMO_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip,
    input  logic             in_hit,
    input  logic             cycle_start,
    input  logic [TMO_W-1:0] tmo_code,
    input  logic             latch_clr,
    output logic             qual,
    output logic             cyc_flag,
    output logic             lat_flag
);
    localparam int CW = (1 << TMO_W) - 1;

    logic [CW-1:0] consec, consec_inc, consec_eff;
    logic [CW:0]   need, tally;

    assign consec_inc = (&consec) ? consec : consec + CW'(1);
    assign consec_eff = cycle_start ? (in_hit ? consec_inc : '0) : consec;
    assign need       = (CW+1)'(1) << tmo_code;
    assign tally      = {1'b0, consec_eff} + (CW+1)'(1);
    assign qual       = trip && (tally >= need);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            consec   <= '0;
            cyc_flag <= 1'b0;
            lat_flag <= 1'b0;
        end else begin
            consec <= consec_eff;
            if (qual)             cyc_flag <= 1'b1;
            else if (cycle_start) cyc_flag <= 1'b0;
            if (qual)             lat_flag <= 1'b1;
            else if (latch_clr)   lat_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ocp_cycle_flag.sv
module ocp_cycle_flag
    import ocp_flag_pkg::*;
#(
    parameter int NREF        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TICK_NS     = 40,
    parameter int DEB_W       = 2,
    parameter int TMO_W       = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_raw,
    input  logic [NREF-1:0]         pwm_ref,
    input  logic [$clog2(NREF)-1:0] ref_sel,
    input  logic                    cycle_start,
    input  logic [BLANK_CODE_W-1:0] blank_code,
    input  logic [DEB_W-1:0]        deb_code,
    input  logic [TMO_W-1:0]        tmo_code,
    input  logic                    latch_clr,
    output logic                    cyc_flag,
    output logic                    lat_flag
);
    localparam int BLANK_STEPS = 1 << BLANK_CODE_W;
    localparam int BW          = $clog2(BLANK_MAX_NS / TICK_NS + 1);

    logic          cmp_sync;
    logic          ref_rise;
    logic          trip;
    logic          in_hit;
    logic          trip_qual;
    win_state_t    win_state;
    logic [BW-1:0] blank_tbl [BLANK_STEPS];
    logic [BW-1:0] blank_len;

    for (genvar g = 0; g < BLANK_STEPS; g++) begin : g_blank
        assign blank_tbl[g] = BW'(blank_ns(BLANK_CODE_W'(g)) / TICK_NS);
    end
    assign blank_len = blank_tbl[blank_code];

    ocp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_raw),
        .q     (cmp_sync)
    );

    ocp_ref_edge #(.NREF(NREF)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_ref  (pwm_ref),
        .ref_sel  (ref_sel),
        .ref_rise (ref_rise)
    );

    ocp_window_fsm #(.BW(BW), .DEB_W(DEB_W)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_rise    (ref_rise),
        .cycle_start (cycle_start),
        .cmp_s       (cmp_sync),
        .blank_len   (blank_len),
        .deb_len     (deb_code),
        .st          (win_state),
        .trip        (trip),
        .in_hit      (in_hit)
    );

    ocp_trip_track #(.TMO_W(TMO_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip        (trip),
        .in_hit      (in_hit),
        .cycle_start (cycle_start),
        .tmo_code    (tmo_code),
        .latch_clr   (latch_clr),
        .qual        (trip_qual),
        .cyc_flag    (cyc_flag),
        .lat_flag    (lat_flag)
    );
endmodule

// File: rtl/ocp_cycle_flag_chk.sv
module ocp_cycle_flag_chk
    import ocp_flag_pkg::*;
#(
    parameter int DEB_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cycle_start,
    input logic             latch_clr,
    input logic [DEB_W-1:0] deb_code,
    input logic             cmp_s,
    input win_state_t       st,
    input logic             qual,
    input logic             cyc_flag,
    input logic             lat_flag
);
    AST_BLANK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLANK) |=> !$rose(cyc_flag)); // R3

    AST_DEB_LAST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_flag) |-> $past(cmp_s)); // R5

    AST_DEB_RUN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cyc_flag) && $past(deb_code) != '0) |-> $past(cmp_s, 2)); // R5

    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_flag && !cycle_start) |=> cyc_flag); // R6

    AST_LAT_WITH_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_flag) |-> lat_flag); // R8

    AST_LAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_clr && !qual) |=> !lat_flag); // R8

    AST_LAT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> (lat_flag && cyc_flag)); // R9
endmodule

bind ocp_cycle_flag ocp_cycle_flag_chk #(.DEB_W(DEB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .latch_clr   (latch_clr),
    .deb_code    (deb_code),
    .cmp_s       (cmp_sync),
    .st          (win_state),
    .qual        (trip_qual),
    .cyc_flag    (cyc_flag),
    .lat_flag    (lat_flag)
);

// File: tb/sim_ocp_cycle_flag.sv
`timescale 1ns/1ps
module sim_ocp_cycle_flag;
    localparam int CLK_PERIOD = 40;
    localparam int CYC_LEN    = 30;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 18;

    // {sel[2], drive bit[2], blank[3], deb[2], k[8], L[8], expected cyc_flag[1]}
    localparam logic [25:0] VECS [0:NV-1] = '{
        {2'd0, 2'd0, 3'd0, 2'd0, 8'd0,  8'd1,  1'b1},
        {2'd1, 2'd1, 3'd4, 2'd0, 8'd1,  8'd3,  1'b0},
        {2'd1, 2'd1, 3'd4, 2'd0, 8'd1,  8'd4,  1'b1},
        {2'd2, 2'd2, 3'd7, 2'd0, 8'd5,  8'd15, 1'b1},
        {2'd2, 2'd2, 3'd7, 2'd0, 8'd5,  8'd14, 1'b0},
        {2'd3, 2'd3, 3'd0, 2'd3, 8'd3,  8'd4,  1'b1},
        {2'd3, 2'd3, 3'd0, 2'd3, 8'd3,  8'd3,  1'b0},
        {2'd0, 2'd0, 3'd2, 2'd1, 8'd0,  8'd2,  1'b0},
        {2'd0, 2'd0, 3'd2, 2'd1, 8'd0,  8'd3,  1'b1},
        {2'd1, 2'd1, 3'd5, 2'd2, 8'd8,  8'd5,  1'b1},
        {2'd1, 2'd1, 3'd3, 2'd2, 8'd10, 8'd2,  1'b0},
        {2'd2, 2'd0, 3'd7, 2'd0, 8'd0,  8'd1,  1'b1},
        {2'd2, 2'd2, 3'd7, 2'd0, 8'd0,  8'd1,  1'b0},
        {2'd0, 2'd0, 3'd1, 2'd0, 8'd0,  8'd1,  1'b1},
        {2'd0, 2'd0, 3'd3, 2'd0, 8'd0,  8'd2,  1'b0},
        {2'd0, 2'd0, 3'd3, 2'd0, 8'd0,  8'd3,  1'b1},
        {2'd0, 2'd0, 3'd6, 2'd0, 8'd10, 8'd4,  1'b0},
        {2'd0, 2'd0, 3'd6, 2'd0, 8'd10, 8'd5,  1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0;
    logic [3:0] pwm_ref = '0;
    logic [1:0] ref_sel = '0;
    logic       cycle_start = 1'b0;
    logic [2:0] blank_code = '0;
    logic [1:0] deb_code = '0;
    logic [1:0] tmo_code = '0;
    logic       latch_clr = 1'b0;
    logic       cyc_flag;
    logic       lat_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_cycle_flag u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_raw     (cmp_raw),
        .pwm_ref     (pwm_ref),
        .ref_sel     (ref_sel),
        .cycle_start (cycle_start),
        .blank_code  (blank_code),
        .deb_code    (deb_code),
        .tmo_code    (tmo_code),
        .latch_clr   (latch_clr),
        .cyc_flag    (cyc_flag),
        .lat_flag    (lat_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One switching cycle; entered and left at a falling clock edge.
    task automatic run_cycle(input logic [31:0] mask, input logic [1:0] drv, input int clr_at);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        pwm_ref[drv] = 1'b1;
        for (int i = 0; i < CYC_LEN; i++) begin
            cmp_raw   = mask[i];
            latch_clr = (i == clr_at);
            if (i == 24) pwm_ref = '0;
            @(negedge clk);
        end
        cmp_raw   = 1'b0;
        latch_clr = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] sel, input logic [2:0] b, input logic [1:0] d, input logic [1:0] t);
        ref_sel = sel; blank_code = b; deb_code = d; tmo_code = t;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cmp_raw = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "cyc_flag in reset", cyc_flag, 1'b0);
        check("R1", "lat_flag in reset", lat_flag, 1'b0);
        cmp_raw = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cyc_flag after reset", cyc_flag, 1'b0);
        check("R1", "lat_flag after reset", lat_flag, 1'b0);

        // Vector table: R2 select, R3 blanking, R5 debounce, R6 hold to cycle end
        for (int v = 0; v < NV; v++) begin
            logic [31:0] m;
            m = ((32'd1 << VECS[v][8:1]) - 32'd1) << VECS[v][16:9];
            set_cfg(VECS[v][25:24], VECS[v][21:19], VECS[v][18:17], 2'd0);
            run_cycle(m, VECS[v][23:22], -1);
            check("R2/R3/R5/R6", $sformatf("vector %0d cyc_flag", v), cyc_flag, VECS[v][0]);
        end

        // R5: a low sample restarts the debounce count
        set_cfg(2'd0, 3'd0, 2'd3, 2'd0);
        run_cycle(32'h0000_0077, 2'd0, -1);
        check("R5", "interrupted debounce", cyc_flag, 1'b0);
        run_cycle(32'h0000_00F7, 2'd0, -1);
        check("R5", "four samples after a gap", cyc_flag, 1'b1);

        // R8: explicit clear
        latch_clr = 1'b1;
        @(negedge clk);
        latch_clr = 1'b0;
        check("R8", "lat_flag after clear", lat_flag, 1'b0);

        // R7: four-cycle timeout
        set_cfg(2'd0, 3'd0, 2'd0, 2'd2);
        run_cycle(32'h0, 2'd0, -1);
        check("R7", "idle cycle", cyc_flag, 1'b0);
        for (int c = 1; c <= 4; c++) begin
            run_cycle(32'h1, 2'd0, -1);
            check("R7", $sformatf("4-run cycle %0d cyc_flag", c), cyc_flag, c == 4);
            check("R7", $sformatf("4-run cycle %0d lat_flag", c), lat_flag, c == 4);
        end
        run_cycle(32'h0, 2'd0, -1);
        check("R6", "cleared by next cycle start", cyc_flag, 1'b0);
        check("R8", "latched across cycle start", lat_flag, 1'b1);
        run_cycle(32'h1, 2'd0, -1);
        check("R7", "run restarted after idle cycle", cyc_flag, 1'b0);

        // R7: eight-cycle timeout and saturation
        set_cfg(2'd0, 3'd0, 2'd0, 2'd3);
        run_cycle(32'h0, 2'd0, -1);
        for (int c = 1; c <= 9; c++) begin
            run_cycle(32'h1, 2'd0, -1);
            check("R7", $sformatf("8-run cycle %0d cyc_flag", c), cyc_flag, c >= 8);
        end

        // R9: trip and clear on the same edge
        latch_clr = 1'b1;
        @(negedge clk);
        latch_clr = 1'b0;
        check("R8", "lat_flag cleared again", lat_flag, 1'b0);
        set_cfg(2'd0, 3'd0, 2'd0, 2'd0);
        run_cycle(32'h1, 2'd0, 2);
        check("R9", "lat_flag with coincident clear", lat_flag, 1'b1);
        check("R9", "cyc_flag with coincident clear", cyc_flag, 1'b1);

        // R4: synchronizer latency
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        pwm_ref[0]  = 1'b1;
        cmp_raw     = 1'b1;
        @(negedge clk);
        check("R4", "after edge 0", cyc_flag, 1'b0);
        @(negedge clk);
        check("R4", "after edge 1", cyc_flag, 1'b0);
        @(negedge clk);
        check("R4", "after edge 2", cyc_flag, 1'b1);
        cmp_raw = 1'b0;
        pwm_ref = '0;
        repeat (4) @(negedge clk);

        // R1: reset while both flags are set
        check("R1", "lat_flag set before reset", lat_flag, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R1", "cyc_flag async reset", cyc_flag, 1'b0);
        check("R1", "lat_flag async reset", lat_flag, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule